// File: doc/BRIEF.md
# JTAG Data Register Bank Selector

This block is the data-register half of a test access port. It contains a one-stage bypass register and a 32-bit identification register. It also offers connection points for an external boundary-scan chain and one user data register, for example a self-test launch and result register. The code held in the instruction register picks exactly one of these four registers to sit between the serial input and the serial output. Only that register receives the capture, shift and update strobes coming from the TAP controller. The other registers keep their contents.

The TAP controller, the instruction register and the boundary cells are outside this block. The TAP controller supplies one-cycle strobes for capture, shift and update that are synchronous to the test clock. The instruction register supplies a stable code. The boundary and user registers each return their serial output bit through `bsr_so` and `user_so`, and this block gates their strobes. The serial output is launched on the falling edge of the test clock. A separate output enable lets the pad drive only while data is being shifted.

Top module: `jtag_dr_bank`

## Requirements
- R1: Exactly one select line is high at all times. Code 0 and code 1 select the boundary register, code 2 (also the reset default of the instruction register) selects identification, and code 3 selects the user register. Every other code, including all ones (15), selects bypass.
- R2: With bypass selected and shift_dr high, the bypass register is one stage. A bit presented on tdi appears on tdo at the falling edge that follows the next rising edge.
- R3: A capture with bypass selected loads 0 into the bypass register.
- R4: A capture with identification selected loads the 32-bit constant ID_VALUE with bit 0 forced to 1. While shifting, the register moves toward bit 0, tdi enters at bit 31, and bit 0 is presented on tdo.
- R5: When trst_n is low, the bypass register is 0, the identification register holds the constant described in R4, and tdo and tdo_oe are 0.
- R6: tdo and tdo_oe change only on the falling edge of tck. After a falling edge, tdo_oe equals the value shift_dr had at that edge.
- R7: bsr_capture, bsr_shift and bsr_update copy capture_dr, shift_dr and update_dr only while the boundary register is selected. user_capture, user_shift and user_update do the same only while the user register is selected. Otherwise all six are 0.
- R8: A register that is not selected keeps its contents across capture, shift and update strobes. A partly shifted identification value therefore resumes where it stopped when identification is selected again.
- R9: With the boundary or user register selected, tdo carries bsr_so or user_so as sampled at the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| ir_code | input | IR_W | Current instruction code |
| capture_dr | input | 1 | Capture strobe from the TAP controller |
| shift_dr | input | 1 | Shift strobe from the TAP controller |
| update_dr | input | 1 | Update strobe from the TAP controller |
| tdi | input | 1 | Serial test data in |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| user_so | input | 1 | Serial output of the external user register |
| sel_bypass | output | 1 | Bypass register selected |
| sel_id | output | 1 | Identification register selected |
| sel_bsr | output | 1 | Boundary register selected |
| sel_user | output | 1 | User register selected |
| bsr_capture | output | 1 | Gated capture strobe to the boundary chain |
| bsr_shift | output | 1 | Gated shift strobe to the boundary chain |
| bsr_update | output | 1 | Gated update strobe to the boundary chain |
| user_capture | output | 1 | Gated capture strobe to the user register |
| user_shift | output | 1 | Gated shift strobe to the user register |
| user_update | output | 1 | Gated update strobe to the user register |
| tdo | output | 1 | Serial test data out, launched on the falling edge |
| tdo_oe | output | 1 | Output enable for the tdo pad |

## Verification
The hardest case to reach is the retention rule for a register that is not selected. The identification register has to be stopped partway through a shift, other registers have to be captured and shifted in the meantime, and then the remaining identification bits have to come out in order. A directed sequence shifts 13 identification bits, switches to bypass and to the boundary code while strobing, then shifts the rest. Long random runs mix all instruction codes with capture, shift and update strobes, and a bench model of both internal registers predicts every tdo bit.

// File: rtl/jtag_dr_bank.sv
module jtag_dr_bank #(
  parameter int          IR_W       = 4,
  parameter int          ID_W       = 32,
  parameter logic [31:0] ID_VALUE   = 32'h1A5C_3E27,
  parameter logic [3:0]  OP_BSR_EXT = 4'h0,
  parameter logic [3:0]  OP_BSR_SMP = 4'h1,
  parameter logic [3:0]  OP_IDCODE  = 4'h2,
  parameter logic [3:0]  OP_USER    = 4'h3
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic [IR_W-1:0] ir_code,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            tdi,
  input  logic            bsr_so,
  input  logic            user_so,
  output logic            sel_bypass,
  output logic            sel_id,
  output logic            sel_bsr,
  output logic            sel_user,
  output logic            bsr_capture,
  output logic            bsr_shift,
  output logic            bsr_update,
  output logic            user_capture,
  output logic            user_shift,
  output logic            user_update,
  output logic            tdo,
  output logic            tdo_oe
);
  localparam logic [ID_W-1:0] ID_CAP = ID_VALUE[ID_W-1:0] | {{(ID_W-1){1'b0}}, 1'b1};

  logic            byp_q;
  logic [ID_W-1:0] id_q;
  logic            tdo_q, oe_q;
  logic            so_mux;

  assign sel_bsr    = (ir_code == OP_BSR_EXT[IR_W-1:0]) || (ir_code == OP_BSR_SMP[IR_W-1:0]);
  assign sel_id     = (ir_code == OP_IDCODE[IR_W-1:0]);
  assign sel_user   = (ir_code == OP_USER[IR_W-1:0]);
  assign sel_bypass = !(sel_bsr || sel_id || sel_user);

  assign bsr_capture  = capture_dr && sel_bsr;
  assign bsr_shift    = shift_dr   && sel_bsr;
  assign bsr_update   = update_dr  && sel_bsr;
  assign user_capture = capture_dr && sel_user;
  assign user_shift   = shift_dr   && sel_user;
  assign user_update  = update_dr  && sel_user;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                       byp_q <= 1'b0;
    else if (capture_dr && sel_bypass) byp_q <= 1'b0;
    else if (shift_dr && sel_bypass)   byp_q <= tdi;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                   id_q <= ID_CAP;
    else if (capture_dr && sel_id) id_q <= ID_CAP;
    else if (shift_dr && sel_id)   id_q <= {tdi, id_q[ID_W-1:1]};
  end

  always_comb begin
    if (sel_bypass)  so_mux = byp_q;
    else if (sel_id) so_mux = id_q[0];
    else if (sel_bsr) so_mux = bsr_so;
    else             so_mux = user_so;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= so_mux;
      oe_q  <= shift_dr;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;

  p_one_select_r1: assert property (@(posedge tck) disable iff (!trst_n)
    $countones({sel_bypass, sel_id, sel_bsr, sel_user}) == 1);

  p_bypass_capture_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && sel_bypass) |=> (byp_q == 1'b0));

  p_id_capture_lsb_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && sel_id) |=> id_q[0]);

  p_id_shift_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_dr && !capture_dr && sel_id) |=> (id_q[ID_W-2:0] == $past(id_q[ID_W-1:1])));

  p_id_hold_r8: assert property (@(posedge tck) disable iff (!trst_n)
    !sel_id |=> $stable(id_q));

  p_bypass_hold_r8: assert property (@(posedge tck) disable iff (!trst_n)
    !sel_bypass |=> $stable(byp_q));

  p_no_stray_strobe_r7: assert property (@(posedge tck) disable iff (!trst_n)
    !(bsr_shift && user_shift));
endmodule

// File: tb/jtag_dr_bank_tb.sv
module jtag_dr_bank_tb;
  localparam logic [31:0] IDV = 32'h1A5C_3E27;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic [3:0] ir_code = 4'h2;
  logic       capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0, bsr_so = 0, user_so = 0;
  logic sel_bypass, sel_id, sel_bsr, sel_user;
  logic bsr_capture, bsr_shift, bsr_update, user_capture, user_shift, user_update;
  logic tdo, tdo_oe;

  int checks = 0;
  int fails  = 0;
  logic        m_byp = 1'b0;
  logic [31:0] m_id  = IDV | 32'd1;

  jtag_dr_bank u_dut (
    .tck(tck), .trst_n(trst_n), .ir_code(ir_code),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .bsr_so(bsr_so), .user_so(user_so),
    .sel_bypass(sel_bypass), .sel_id(sel_id), .sel_bsr(sel_bsr), .sel_user(sel_user),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .user_capture(user_capture), .user_shift(user_shift), .user_update(user_update),
    .tdo(tdo), .tdo_oe(tdo_oe)
  );

  always #10 tck = ~tck;

  // 0 bypass, 1 id, 2 boundary, 3 user
  function automatic int exp_sel(input logic [3:0] c);
    if (c == 4'h0 || c == 4'h1) return 2;
    if (c == 4'h2) return 1;
    if (c == 4'h3) return 3;
    return 0;
  endfunction

  function automatic logic exp_so(input logic [3:0] c);
    case (exp_sel(c))
      0: return m_byp;
      1: return m_id[0];
      2: return bsr_so;
      default: return user_so;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] c, input logic cap, input logic sh,
                     input logic upd, input logic din);
    int s;
    logic eso;
    @(posedge tck); #1;
    ir_code = c; capture_dr = cap; shift_dr = sh; update_dr = upd; tdi = din;
    bsr_so = 1'($urandom); user_so = 1'($urandom);
    eso = exp_so(c);
    @(negedge tck); #1;
    s = exp_sel(c);
    chk("R1", {sel_bypass, sel_id, sel_bsr, sel_user},
        {31'd0, s == 3} | {30'd0, s == 2, 1'b0} | {29'd0, s == 1, 2'b0} | {28'd0, s == 0, 3'b0});
    chk("R7", {bsr_capture, bsr_shift, bsr_update, user_capture, user_shift, user_update},
        {26'd0, cap && s == 2, sh && s == 2, upd && s == 2, cap && s == 3, sh && s == 3, upd && s == 3});
    chk("R6", tdo_oe, sh);
    if (sh) begin
      if (s >= 2) chk("R9", tdo, eso);
      else        chk(s == 0 ? "R2" : "R4", tdo, eso);
    end
    if (s == 0) begin
      if (cap) m_byp = 1'b0;
      else if (sh) m_byp = din;
    end
    if (s == 1) begin
      if (cap) m_id = IDV | 32'd1;
      else if (sh) m_id = {din, m_id[31:1]};
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] got;
    void'($urandom(32'd7321));
    #35;
    chk("R5", {tdo, tdo_oe}, 0);
    trst_n = 1'b1;
    // R5: reset value of the identification register shifts out unchanged
    got = '0;
    for (int i = 0; i < 32; i++) begin
      cyc(4'h2, 0, 1, 0, 1'b0);
      got[i] = tdo;
    end
    chk("R5", got, IDV | 32'd1);
    // R3 then R2: bypass capture gives 0, then one-stage delay
    cyc(4'hF, 1, 0, 0, 0);
    cyc(4'hF, 0, 1, 0, 1);
    chk("R3", tdo, 0);
    cyc(4'hF, 0, 1, 0, 0);
    chk("R2", tdo, 1);
    cyc(4'h9, 0, 1, 0, 1);
    chk("R1", sel_bypass, 1);
    // R4: capture then read out, LSB first
    cyc(4'h2, 1, 0, 0, 0);
    got = '0;
    for (int i = 0; i < 13; i++) begin
      cyc(4'h2, 0, 1, 0, 1'b0);
      got[i] = tdo;
    end
    // R8: other registers active in between
    cyc(4'hF, 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(4'hF, 0, 1, 0, 1'($urandom));
    cyc(4'h0, 1, 0, 0, 0);
    cyc(4'h0, 0, 1, 0, 1);
    cyc(4'h3, 0, 0, 1, 0);
    for (int i = 13; i < 32; i++) begin
      cyc(4'h2, 0, 1, 0, 1'b0);
      got[i] = tdo;
    end
    chk("R8", got, IDV | 32'd1);
    // R4: tdi enters at the top of the identification register
    for (int i = 0; i < 32; i++) cyc(4'h2, 0, 1, 0, 1'b1);
    got = '0;
    for (int i = 0; i < 32; i++) begin
      cyc(4'h2, 0, 1, 0, 1'b0);
      got[i] = tdo;
    end
    chk("R4", got, 32'hFFFF_FFFF);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [3:0] c;
      k = int'($urandom % 4);
      c = ($urandom % 4 == 0) ? 4'($urandom) : ((k == 3) ? 4'hF : 4'(k));
      k = int'($urandom % 4);
      cyc(c, k == 1, k == 2, k == 3, 1'($urandom));
    end
    // R5: asynchronous reset mid-shift
    @(posedge tck); #3;
    trst_n = 1'b0;
    #2;
    chk("R5", {tdo, tdo_oe}, 0);
    trst_n = 1'b1;
    m_byp = 1'b0;
    m_id = IDV | 32'd1;
    cyc(4'h2, 0, 1, 0, 0);
    cyc(4'h4, 0, 1, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule